// File: doc/BRIEF.md
# Falling-Edge Dual-Read Register File

A general-purpose register array with one write port and two independent read ports, intended for a single-issue datapath. Each read port takes a register index and drives a data bus. The write port takes an index, a data word and an enable. A write is captured on the falling clock edge. Reads are purely combinational, so an operand fetched in the second half of a cycle already shows the value written at that cycle's falling edge.

One entry, index 31 by default, is a constant-zero register. It reads as zero on both ports from time zero, and writes aimed at it have no visible effect. A parameter selects how this is built:

- The default drops writes to that index and keeps no storage for it.
- The alternative stores the write and forces the read buses to zero.

There is no reset. All other entries hold unknown values until they are first written.

Top module: `fe_regfile`

## Requirements
- R1: With default parameters the array holds 32 independent entries of 64 bits each, addressed by 5-bit indices 0 to 31, and every one of indices 0 to 30 can hold a distinct value at the same time.
- R2: `rd_data_a` shows the contents of entry `rd_idx_a` combinationally, with no clock edge between an index change and the data.
- R3: `rd_data_b` shows the contents of entry `rd_idx_b` combinationally and independently of port A.
- R4: When `wr_en` is 1 at a falling edge of `clk`, `wr_data` is stored into entry `wr_idx` at that edge and not before. Between the preceding rising edge and that falling edge, the entry still reads its old value.
- R5: A value written at a falling edge is visible on the read buses before the next rising edge.
- R6: Index 31 reads as all zeros on both buses at all times, including before any write.
- R7: A write with `wr_idx` = 31 leaves index 31 reading zero and changes no other entry.
- R8: When `wr_en` is 0 at a falling edge, no entry changes, whatever `wr_idx` and `wr_data` hold.
- R9: When `rd_idx_a` equals `rd_idx_b`, both buses carry the same value.
- R10: A write changes only the addressed entry. All other entries keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes occur on its falling edge |
| wr_en | input | 1 | Write enable, sampled at the falling edge |
| wr_idx | input | 5 | Index of the entry to write |
| wr_data | input | 64 | Data to store |
| rd_idx_a | input | 5 | Index for read port A |
| rd_data_a | output | 64 | Contents of entry `rd_idx_a` |
| rd_idx_b | input | 5 | Index for read port B |
| rd_data_b | output | 64 | Contents of entry `rd_idx_b` |

## Verification
The hardest case to reach from the ports is the half-cycle window between a rising edge and the falling edge, where a pending write must not yet be visible. The stimulus targets it directly. Each write is driven just after a rising edge, and the target entry is read back twice: once before the falling edge, expecting the old value, and once after it, expecting the new one. A second write round with different data over every index makes the old and new values differ. Isolation is shown by sweeping all indices on both ports after single writes, after disabled writes carrying poison data, and after writes to the zero index.

// File: rtl/rf_pkg.sv
package rf_pkg;

   // How the constant-zero entry is realised
   typedef enum logic [1:0] {
      ZR_NONE       = 2'd0,  // no constant-zero entry
      ZR_DROP_WRITE = 2'd1,  // no storage, writes discarded
      ZR_MASK_READ  = 2'd2   // storage kept, read buses forced to zero
   } zero_mode_e;

endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode
   import rf_pkg::*;
#(
   parameter int         NUM_REGS  = 32,
   parameter int         IDX_W     = 5,
   parameter int         ZERO_IDX  = 31,
   parameter zero_mode_e ZERO_MODE = ZR_DROP_WRITE
) (
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    wr_idx,
   output logic [NUM_REGS-1:0] wr_sel
);

   logic [NUM_REGS-1:0] raw_sel;

   always_comb begin
      raw_sel = '0;
      if (wr_en && (int'(wr_idx) < NUM_REGS)) begin
         raw_sel[wr_idx] = 1'b1;
      end
   end

   generate
      if (ZERO_MODE == ZR_DROP_WRITE) begin : g_drop
         localparam logic [NUM_REGS-1:0] KEEP = ~(NUM_REGS'(1) << ZERO_IDX);
         assign wr_sel = raw_sel & KEEP;
      end else begin : g_pass
         assign wr_sel = raw_sel;
      end
   endgenerate

endmodule

// File: rtl/rf_store.sv
module rf_store
   import rf_pkg::*;
#(
   parameter int         NUM_REGS  = 32,
   parameter int         DATA_W    = 64,
   parameter int         ZERO_IDX  = 31,
   parameter zero_mode_e ZERO_MODE = ZR_DROP_WRITE
) (
   input  logic                             clk,
   input  logic [NUM_REGS-1:0]              wr_sel,
   input  logic [DATA_W-1:0]                wr_data,
   output logic [NUM_REGS-1:0][DATA_W-1:0]  entries
);

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_ent
         if ((ZERO_MODE == ZR_DROP_WRITE) && (g == ZERO_IDX)) begin : g_const
            assign entries[g] = '0;
         end else begin : g_reg
            logic [DATA_W-1:0] q;
            always_ff @(negedge clk) begin
               if (wr_sel[g]) begin
                  q <= wr_data;
               end
            end
            assign entries[g] = q;
         end
      end
   endgenerate

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
   import rf_pkg::*;
#(
   parameter int         NUM_REGS  = 32,
   parameter int         DATA_W    = 64,
   parameter int         IDX_W     = 5,
   parameter int         ZERO_IDX  = 31,
   parameter zero_mode_e ZERO_MODE = ZR_DROP_WRITE
) (
   input  logic [NUM_REGS-1:0][DATA_W-1:0] entries,
   input  logic [IDX_W-1:0]                rd_idx,
   output logic [DATA_W-1:0]               rd_data
);

   logic [DATA_W-1:0] picked;

   always_comb begin
      picked = '0;
      if (int'(rd_idx) < NUM_REGS) begin
         picked = entries[rd_idx];
      end
   end

   generate
      if (ZERO_MODE == ZR_MASK_READ) begin : g_mask
         localparam logic [IDX_W-1:0] ZSEL = IDX_W'(ZERO_IDX);
         assign rd_data = (rd_idx == ZSEL) ? '0 : picked;
      end else begin : g_plain
         assign rd_data = picked;
      end
   endgenerate

endmodule

// File: rtl/fe_regfile.sv
module fe_regfile
   import rf_pkg::*;
#(
   parameter int         NUM_REGS  = 32,
   parameter int         DATA_W    = 64,
   parameter int         ZERO_IDX  = 31,
   parameter zero_mode_e ZERO_MODE = ZR_DROP_WRITE,
   localparam int        IDX_W     = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx_a,
   output logic [DATA_W-1:0] rd_data_a,
   input  logic [IDX_W-1:0]  rd_idx_b,
   output logic [DATA_W-1:0] rd_data_b
);

   // elaboration-time parameter checks
   generate
      if (NUM_REGS < 2) begin : g_bad_depth
         $error("fe_regfile: NUM_REGS must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("fe_regfile: DATA_W must be positive");
      end
      if ((ZERO_MODE != ZR_NONE) && ((ZERO_IDX < 0) || (ZERO_IDX >= NUM_REGS))) begin : g_bad_zero
         $error("fe_regfile: ZERO_IDX out of range");
      end
   endgenerate

   logic [NUM_REGS-1:0]             wr_sel;
   logic [NUM_REGS-1:0][DATA_W-1:0] entry_q;

   rf_wr_decode #(
      .NUM_REGS (NUM_REGS),
      .IDX_W    (IDX_W),
      .ZERO_IDX (ZERO_IDX),
      .ZERO_MODE(ZERO_MODE)
   ) u_dec (
      .wr_en (wr_en),
      .wr_idx(wr_idx),
      .wr_sel(wr_sel)
   );

   rf_store #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .ZERO_IDX (ZERO_IDX),
      .ZERO_MODE(ZERO_MODE)
   ) u_store (
      .clk    (clk),
      .wr_sel (wr_sel),
      .wr_data(wr_data),
      .entries(entry_q)
   );

   rf_read_port #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .IDX_W    (IDX_W),
      .ZERO_IDX (ZERO_IDX),
      .ZERO_MODE(ZERO_MODE)
   ) u_rd_a (
      .entries(entry_q),
      .rd_idx (rd_idx_a),
      .rd_data(rd_data_a)
   );

   rf_read_port #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .IDX_W    (IDX_W),
      .ZERO_IDX (ZERO_IDX),
      .ZERO_MODE(ZERO_MODE)
   ) u_rd_b (
      .entries(entry_q),
      .rd_idx (rd_idx_b),
      .rd_data(rd_data_b)
   );

endmodule

// File: rtl/fe_regfile_chk.sv
module fe_regfile_chk
   import rf_pkg::*;
#(
   parameter int         NUM_REGS  = 32,
   parameter int         DATA_W    = 64,
   parameter int         IDX_W     = 5,
   parameter int         ZERO_IDX  = 31,
   parameter zero_mode_e ZERO_MODE = ZR_DROP_WRITE
) (
   input logic                            clk,
   input logic                            wr_en,
   input logic [IDX_W-1:0]                wr_idx,
   input logic [DATA_W-1:0]               wr_data,
   input logic [IDX_W-1:0]                rd_idx_a,
   input logic [DATA_W-1:0]               rd_data_a,
   input logic [IDX_W-1:0]                rd_idx_b,
   input logic [DATA_W-1:0]               rd_data_b,
   input logic [NUM_REGS-1:0][DATA_W-1:0] entry_q
);

   localparam logic [IDX_W-1:0] ZSEL = IDX_W'(ZERO_IDX);
   localparam bit HAS_ZERO = (ZERO_MODE != ZR_NONE);

   logic              armed   = 1'b0;
   logic              cap_en  = 1'b0;
   logic [IDX_W-1:0]  cap_idx = '0;
   logic [DATA_W-1:0] cap_dat = '0;

   always_ff @(negedge clk) begin
      armed   <= 1'b1;
      cap_en  <= wr_en;
      cap_idx <= wr_idx;
      cap_dat <= wr_data;
   end

   AST_ZERO_BUS_A: assert property (@(posedge clk) disable iff (!armed)
      (HAS_ZERO && rd_idx_a == ZSEL) |-> (rd_data_a == '0));              // R6
   AST_ZERO_BUS_B: assert property (@(posedge clk) disable iff (!armed)
      (HAS_ZERO && rd_idx_b == ZSEL) |-> (rd_data_b == '0));              // R6
   AST_SAME_INDEX: assert property (@(posedge clk) disable iff (!armed)
      (rd_idx_a == rd_idx_b) |-> (rd_data_a == rd_data_b));               // R9
   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!armed)
      (cap_en && (int'(cap_idx) < NUM_REGS) && !(HAS_ZERO && cap_idx == ZSEL))
         |-> (entry_q[cap_idx] == cap_dat));                               // R5
   AST_IDLE_HOLDS: assert property (@(negedge clk) disable iff (!armed)
      !wr_en |=> $stable(entry_q));                                        // R8

endmodule

bind fe_regfile fe_regfile_chk #(
   .NUM_REGS (NUM_REGS),
   .DATA_W   (DATA_W),
   .IDX_W    (IDX_W),
   .ZERO_IDX (ZERO_IDX),
   .ZERO_MODE(ZERO_MODE)
) u_chk (
   .clk      (clk),
   .wr_en    (wr_en),
   .wr_idx   (wr_idx),
   .wr_data  (wr_data),
   .rd_idx_a (rd_idx_a),
   .rd_data_a(rd_data_a),
   .rd_idx_b (rd_idx_b),
   .rd_data_b(rd_data_b),
   .entry_q  (entry_q)
);

// File: tb/sim_fe_regfile.sv
module sim_fe_regfile;

   localparam int CLK_PER = 10;
   localparam int NREG    = 32;
   localparam int ZIDX    = 31;

   logic        clk = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_idx = '0;
   logic [63:0] wr_data = '0;
   logic [4:0]  rd_idx_a = 5'd31;
   logic [4:0]  rd_idx_b = 5'd31;
   logic [63:0] rd_data_a, rd_data_b;

   int n_vec = 0;
   int n_bad = 0;
   logic [63:0] model [NREG];

   always #(CLK_PER/2) clk = ~clk;

   fe_regfile u0 (
      .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a),
      .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b)
   );

   function automatic logic [63:0] pat(int i, int round);
      logic [31:0] h;
      h = 32'(i + 1) * 32'h9E37_79B9 + 32'(round) * 32'h85EB_CA6B;
      return {h ^ 32'(round * 7 + 3), ~h + 32'(i)};
   endfunction

   task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   // drive a write after a rising edge; optionally check old value before the falling edge
   task automatic do_write(int idx, logic [63:0] d, bit en, bit pre_chk);
      @(posedge clk);
      #1;
      wr_en = en; wr_idx = 5'(idx); wr_data = d;
      rd_idx_a = 5'(idx);
      #1;
      if (pre_chk) check("R4 before falling edge", rd_data_a, model[idx]);
      @(negedge clk);
      #1;
      wr_en = 1'b0;
      if (en && idx != ZIDX) model[idx] = d;
   endtask

   task automatic sweep(string tag);
      for (int a = 0; a < NREG; a++) begin
         rd_idx_a = 5'(a);
         rd_idx_b = 5'(NREG - 1 - a);
         #1;
         check({tag, " R2 port A"}, rd_data_a, model[a]);
         check({tag, " R3 port B"}, rd_data_b, model[NREG - 1 - a]);
      end
   endtask

   initial begin
      for (int i = 0; i < NREG; i++) model[i] = 'x;
      model[ZIDX] = '0;
      #1;
      check("R6 zero before writes A", rd_data_a, 64'd0);
      check("R6 zero before writes B", rd_data_b, 64'd0);

      // round 0: fill every entry, check visibility in the same cycle
      for (int i = 0; i < NREG; i++) begin
         do_write(i, pat(i, 0), 1'b1, 1'b0);
         check("R5 visible before rising edge", rd_data_a, (i == ZIDX) ? 64'd0 : pat(i, 0));
      end
      sweep("R1 after fill");

      // round 1: new data, old value must hold until the falling edge
      for (int i = 0; i < NREG; i++) begin
         do_write(i, pat(i, 1), 1'b1, 1'b1);
         check("R4 after falling edge", rd_data_a, model[i]);
      end
      sweep("R1 after rewrite");

      // disabled writes carrying poison data
      for (int i = 0; i < NREG; i++) begin
         do_write(i, ~model[i], 1'b0, 1'b0);
         check("R8 disabled write", rd_data_a, model[i]);
      end
      sweep("R8 sweep");

      // writes to the zero index
      do_write(ZIDX, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0);
      check("R7 zero index after write", rd_data_a, 64'd0);
      sweep("R7 sweep");

      // isolation: single writes followed by full sweeps
      for (int k = 0; k < NREG; k += 5) begin
         do_write(k, pat(k, 9), 1'b1, 1'b0);
         sweep("R10 isolation");
      end

      // same index on both ports
      for (int i = 0; i < NREG; i++) begin
         rd_idx_a = 5'(i);
         rd_idx_b = 5'(i);
         #1;
         check("R9 same index equal", rd_data_b, rd_data_a);
         check("R9 same index value", rd_data_b, model[i]);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PER * 200000);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule